// File: doc/BRIEF.md
# Slot-Table Thread Picker

This block sits at the front of a fine-grained multithreaded pipeline and chooses, on every clock, which hardware thread may fetch next. It walks a small table of scheduling slots. Each slot names one thread, and the pointer moves forward by one slot per cycle. Software fills the table through a write port. A thread that appears in more slots gets a larger share of the issue bandwidth. Software can also rewrite the table while the block runs, to change which thread is favoured.

The block holds one program counter per thread. It presents the thread in the current slot, that thread's PC and a valid bit. Each thread has a ready input. When the thread in the current slot is not ready, that slot becomes a dead cycle, and no other thread is moved up to fill it. The choice does not depend on instruction latency or on dependencies between instructions. A PC moves forward only when downstream logic accepts a valid issue.

Table and length updates are held in a pending copy. The pending copy is moved into the live table only when the pointer wraps, so each scheduling round uses one consistent table.

Top module: `mt_slot_picker`

## Requirements
- R1: After reset, the live and pending tables hold threads 0,1,2,3,0,1,2,3 in slots 0 to 7, the active length is 4, the pointer is at slot 0, and every thread's PC equals RESET_VEC.
- R2: The slot pointer moves forward by exactly one slot on every clock, whatever the state of valid and accept. After the last active slot (length minus one) it returns to slot 0.
- R3: When issue_valid_o and accept_i are both high, the PC of the thread on issue_tid_o grows by 4 at the next clock. issue_pc_o always shows the PC of the thread in the current slot.
- R4: A PC changes only through R3. When valid or accept is low, or when a thread is not the one being issued, its PC keeps its value.
- R5: issue_valid_o is high exactly when the ready bit of the current slot's thread is high. A slot whose thread is not ready is a dead cycle. issue_tid_o still shows that slot's thread, and no other thread issues in its place.
- R6: A slot write (slot_wr_i, with slot index and 2-bit thread ID) goes into the live table at the next wrap of the pointer, not before. A write presented in the cycle where the pointer sits on the last active slot takes effect one round later.
- R7: A length write with a value from 1 to 8 takes effect at the next wrap, the same way as R6. A length write of 0, or of more than 8, is ignored.
- R8: A thread placed in several active slots issues once for each of them in a round. For example, the table 0,1,0,2,0,3 with length 6 gives thread 0 three issues per round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| slot_wr_i | input | 1 | Write one slot of the pending table |
| slot_wr_idx_i | input | 3 | Slot index for the write |
| slot_wr_tid_i | input | 2 | Thread ID written into the slot |
| len_wr_i | input | 1 | Write the pending active length |
| len_wr_val_i | input | 4 | New active length (1 to 8 accepted) |
| thr_ready_i | input | 4 | Per-thread ready bits |
| accept_i | input | 1 | Downstream takes the current issue |
| issue_valid_o | output | 1 | Current slot's thread is ready to issue |
| issue_tid_o | output | 2 | Thread in the current slot |
| issue_pc_o | output | 32 | PC of that thread |

## Verification
The bench starves one thread across a whole round. It then checks that the thread's slots come out as dead cycles and that its PC has not moved, while the other threads keep going. A design that passed the slot to another ready thread would show the wrong valid bit, and would also show PCs that advanced too far. Writes go into the table halfway through a round and also in the wrap cycle itself. A design that applied them at once, or one cycle too early, would mix entries from two tables inside one round. Length writes of 0 and 9 check the range guard. A length of 1 checks that the pointer can stay on slot 0 when the round is only one slot long.

// File: rtl/mt_pick_pkg.sv
package mt_pick_pkg;
    // Shared configuration defaults for the slot-table picker
    localparam int unsigned DEF_THREADS = 4;
    localparam int unsigned DEF_SLOTS   = 8;
    localparam int unsigned DEF_PC_W    = 32;
    localparam int unsigned PC_STEP     = 4;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mt_slot_table.sv
module mt_slot_table
    import mt_pick_pkg::*;
#(
    parameter int unsigned NUM_THREADS = DEF_THREADS,
    parameter int unsigned SLOTS       = DEF_SLOTS,
    parameter int unsigned RESET_LEN   = DEF_THREADS,
    localparam int unsigned TID_W      = width_of(NUM_THREADS),
    localparam int unsigned SLOT_W     = width_of(SLOTS),
    localparam int unsigned LEN_W      = $clog2(SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SLOT_W-1:0]        wr_idx,
    input  logic [TID_W-1:0]         wr_tid,
    input  logic                     len_we,
    input  logic [LEN_W-1:0]         len_val,
    output logic [TID_W-1:0]         cur_tid,
    output logic [SLOT_W-1:0]        ptr,
    output logic [LEN_W-1:0]         act_len,
    output logic [SLOTS*TID_W-1:0]   act_flat
);
    typedef logic [SLOTS-1:0][TID_W-1:0] tbl_t;

    typedef struct packed {
        tbl_t              pend;
        tbl_t              act;
        logic [LEN_W-1:0]  pend_len;
        logic [LEN_W-1:0]  act_len;
        logic [SLOT_W-1:0] ptr;
    } tbl_state_t;

    function automatic tbl_t reset_table();
        tbl_t t;
        for (int i = 0; i < int'(SLOTS); i++) begin
            t[i] = TID_W'(i % int'(NUM_THREADS));
        end
        return t;
    endfunction

    tbl_state_t st_d, st_q;
    logic       at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (32'(st_q.ptr) + 32'd1) == 32'(st_q.act_len);

        // software updates land in the pending copy only
        if (wr_en && (32'(wr_idx) < SLOTS)) begin
            st_d.pend[wr_idx] = wr_tid;
        end
        if (len_we && (len_val != '0) && (32'(len_val) <= SLOTS)) begin
            st_d.pend_len = len_val;
        end

        // pointer steps every cycle; the live table swaps only on wrap
        if (at_last) begin
            st_d.ptr     = '0;
            st_d.act     = st_q.pend;
            st_d.act_len = st_q.pend_len;
        end else begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend     <= reset_table();
            st_q.act      <= reset_table();
            st_q.pend_len <= LEN_W'(RESET_LEN);
            st_q.act_len  <= LEN_W'(RESET_LEN);
            st_q.ptr      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_tid  = st_q.act[st_q.ptr];
    assign ptr      = st_q.ptr;
    assign act_len  = st_q.act_len;
    assign act_flat = st_q.act;
endmodule

// File: rtl/mt_pc_bank.sv
module mt_pc_bank
    import mt_pick_pkg::*;
#(
    parameter int unsigned NUM_THREADS = DEF_THREADS,
    parameter int unsigned PC_W        = DEF_PC_W,
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_1000,
    localparam int unsigned TID_W      = width_of(NUM_THREADS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                adv,
    input  logic [TID_W-1:0]                    adv_tid,
    output logic [NUM_THREADS-1:0][PC_W-1:0]    pc_all
);
    typedef struct packed {
        logic [NUM_THREADS-1:0][PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;
    logic [NUM_THREADS-1:0] hit;

    // one advance-enable per thread context
    for (genvar t = 0; t < int'(NUM_THREADS); t++) begin : g_hit
        assign hit[t] = adv && (32'(adv_tid) == t);
    end

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < int'(NUM_THREADS); t++) begin
            if (hit[t]) begin
                st_d.pc[t] = st_q.pc[t] + PC_W'(PC_STEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < int'(NUM_THREADS); t++) begin
                st_q.pc[t] <= RESET_VEC;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_all = st_q.pc;
endmodule

// File: rtl/mt_slot_picker.sv
module mt_slot_picker
    import mt_pick_pkg::*;
#(
    parameter int unsigned NUM_THREADS = DEF_THREADS,
    parameter int unsigned SLOTS       = DEF_SLOTS,
    parameter int unsigned PC_W        = DEF_PC_W,
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_1000,
    localparam int unsigned TID_W      = width_of(NUM_THREADS),
    localparam int unsigned SLOT_W     = width_of(SLOTS),
    localparam int unsigned LEN_W      = $clog2(SLOTS + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    slot_wr_i,
    input  logic [SLOT_W-1:0]       slot_wr_idx_i,
    input  logic [TID_W-1:0]        slot_wr_tid_i,
    input  logic                    len_wr_i,
    input  logic [LEN_W-1:0]        len_wr_val_i,
    input  logic [NUM_THREADS-1:0]  thr_ready_i,
    input  logic                    accept_i,
    output logic                    issue_valid_o,
    output logic [TID_W-1:0]        issue_tid_o,
    output logic [PC_W-1:0]         issue_pc_o
);
    logic [TID_W-1:0]                 cur_tid;
    logic [SLOT_W-1:0]                slot_ptr;
    logic [LEN_W-1:0]                 act_len;
    logic [SLOTS*TID_W-1:0]           act_flat;
    logic [NUM_THREADS-1:0][PC_W-1:0] pc_all;
    logic                             adv;

    mt_slot_table #(
        .NUM_THREADS (NUM_THREADS),
        .SLOTS       (SLOTS),
        .RESET_LEN   (NUM_THREADS)
    ) u_table (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .wr_en    (slot_wr_i),
        .wr_idx   (slot_wr_idx_i),
        .wr_tid   (slot_wr_tid_i),
        .len_we   (len_wr_i),
        .len_val  (len_wr_val_i),
        .cur_tid  (cur_tid),
        .ptr      (slot_ptr),
        .act_len  (act_len),
        .act_flat (act_flat)
    );

    // dead slot if the owner is not ready; nobody else takes it
    assign issue_valid_o = thr_ready_i[cur_tid];
    assign issue_tid_o   = cur_tid;
    assign adv           = issue_valid_o && accept_i;

    mt_pc_bank #(
        .NUM_THREADS (NUM_THREADS),
        .PC_W        (PC_W),
        .RESET_VEC   (RESET_VEC)
    ) u_pcs (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .adv     (adv),
        .adv_tid (cur_tid),
        .pc_all  (pc_all)
    );

    assign issue_pc_o = pc_all[cur_tid];
endmodule

// File: rtl/mt_slot_picker_chk.sv
module mt_slot_picker_chk
    import mt_pick_pkg::*;
#(
    parameter int unsigned NUM_THREADS = DEF_THREADS,
    parameter int unsigned SLOTS       = DEF_SLOTS,
    parameter int unsigned PC_W        = DEF_PC_W,
    localparam int unsigned TID_W      = width_of(NUM_THREADS),
    localparam int unsigned SLOT_W     = width_of(SLOTS),
    localparam int unsigned LEN_W      = $clog2(SLOTS + 1)
) (
    input logic                             clk_i,
    input logic                             rst_ni,
    input logic                             accept_i,
    input logic                             issue_valid_o,
    input logic [TID_W-1:0]                 issue_tid_o,
    input logic [PC_W-1:0]                  issue_pc_o,
    input logic [SLOT_W-1:0]                slot_ptr,
    input logic [LEN_W-1:0]                 act_len,
    input logic [SLOTS*TID_W-1:0]           act_flat,
    input logic [NUM_THREADS-1:0][PC_W-1:0] pc_all
);
    a_r2_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((32'(slot_ptr) + 32'd1) == 32'(act_len)) |=> (slot_ptr == '0));

    a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((32'(slot_ptr) + 32'd1) != 32'(act_len))
        |=> (32'(slot_ptr) == 32'($past(slot_ptr)) + 32'd1));

    a_r7_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_len != '0) && (32'(act_len) <= SLOTS));

    a_r6_round_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_ptr != '0) |-> ($stable(act_flat) && $stable(act_len)));

    a_r3_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_o && accept_i)
        |=> (pc_all[$past(issue_tid_o)] == $past(issue_pc_o) + PC_W'(PC_STEP)));

    for (genvar t = 0; t < int'(NUM_THREADS); t++) begin : g_hold
        a_r4_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(issue_valid_o && accept_i && (32'(issue_tid_o) == t))
            |=> $stable(pc_all[t]));
    end
endmodule

bind mt_slot_picker mt_slot_picker_chk #(
    .NUM_THREADS (NUM_THREADS),
    .SLOTS       (SLOTS),
    .PC_W        (PC_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept_i),
    .issue_valid_o (issue_valid_o),
    .issue_tid_o   (issue_tid_o),
    .issue_pc_o    (issue_pc_o),
    .slot_ptr      (slot_ptr),
    .act_len       (act_len),
    .act_flat      (act_flat),
    .pc_all        (pc_all)
);

// File: tb/test_mt_slot_picker.sv
`timescale 1ns/1ps
module test_mt_slot_picker;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        slot_wr;
    logic [2:0]  slot_idx;
    logic [1:0]  slot_tid;
    logic        len_wr;
    logic [3:0]  len_val;
    logic [3:0]  ready;
    logic        accept;
    logic        v;
    logic [1:0]  tid;
    logic [31:0] pc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mt_slot_picker i_mt_slot_picker (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .slot_wr_i     (slot_wr),
        .slot_wr_idx_i (slot_idx),
        .slot_wr_tid_i (slot_tid),
        .len_wr_i      (len_wr),
        .len_wr_val_i  (len_val),
        .thr_ready_i   (ready),
        .accept_i      (accept),
        .issue_valid_o (v),
        .issue_tid_o   (tid),
        .issue_pc_o    (pc)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        slot_wr = 0; slot_idx = 0; slot_tid = 0; len_wr = 0; len_val = 0;
    endtask

    // leaves the bench just after a negedge with reset released
    task automatic do_reset();
        idle_in();
        ready = 4'hF; accept = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic step();
        @(negedge clk);
        idle_in();
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            chk(tid == 2'(i % 4), "R1 order", tid, i % 4);
            chk(pc == RV, "R1/R4 pc at reset", pc, RV);
            chk(v == 1'b1, "R5 ready valid", v, 1);
            step();
        end
    endtask

    task automatic t_rotate();
        do_reset();
        accept = 1;
        for (int i = 0; i < 12; i++) begin
            chk(tid == 2'(i % 4), "R2 cyclic order", tid, i % 4);
            chk(pc == RV + 32'(4 * (i / 4)), "R3 pc step", pc, RV + 32'(4 * (i / 4)));
            step();
        end
    endtask

    task automatic t_dead();
        do_reset();
        accept = 1; ready = 4'b1101;
        for (int i = 0; i < 8; i++) begin
            chk(tid == 2'(i % 4), "R5 slot kept by owner", tid, i % 4);
            chk(v == (i % 4 != 1), "R5 dead cycle", v, (i % 4 != 1));
            step();
        end
        ready = 4'hF; accept = 0;
        for (int i = 0; i < 4; i++) begin
            chk(pc == ((i == 1) ? RV : RV + 32'd8), "R4 stalled pc held", pc,
                (i == 1) ? RV : RV + 32'd8);
            step();
        end
    endtask

    task automatic t_table();
        logic [1:0] nt [6] = '{0, 1, 0, 2, 0, 3};
        int n0 = 0;
        do_reset();
        // length 8 written in cycle 0, live after first wrap
        len_wr = 1; len_val = 8;
        for (int i = 0; i < 4; i++) begin
            chk(tid == 2'(i % 4), "R7 old length round", tid, i % 4);
            step();
        end
        for (int i = 0; i < 8; i++) begin
            chk(tid == 2'(i % 4), "R6 round not mixed", tid, i % 4);
            if (i < 6) begin slot_wr = 1; slot_idx = 3'(i); slot_tid = nt[i]; end
            if (i == 6) begin len_wr = 1; len_val = 6; end
            @(negedge clk);
            idle_in();
        end
        accept = 1;
        for (int i = 0; i < 12; i++) begin
            chk(tid == nt[i % 6], "R6 new table", tid, nt[i % 6]);
            if (i < 6 && tid == 0 && v) n0++;
            step();
        end
        chk(n0 == 3, "R8 share of thread 0", n0, 3);
        accept = 0;
        chk(tid == 0 && pc == RV + 32'd24, "R8 pc after six issues", pc, RV + 32'd24);
    endtask

    task automatic t_len();
        do_reset();
        len_wr = 1; len_val = 0;
        @(negedge clk); idle_in();
        len_wr = 1; len_val = 9;
        @(negedge clk); idle_in();
        for (int i = 2; i < 10; i++) begin
            chk(tid == 2'(i % 4), "R7 bad length ignored", tid, i % 4);
            step();
        end
        // now at slot 2 of a round: length 1 live after this round
        len_wr = 1; len_val = 1;
        @(negedge clk); idle_in();
        chk(tid == 3, "R7 round finishes", tid, 3);
        step();
        for (int i = 0; i < 4; i++) begin
            chk(tid == 0, "R7 length one", tid, 0);
            step();
        end
    endtask

    task automatic t_wrap_write();
        do_reset();
        repeat (3) step();
        // pointer on last slot: write lands one round later
        slot_wr = 1; slot_idx = 0; slot_tid = 3;
        @(negedge clk); idle_in();
        for (int i = 0; i < 4; i++) begin
            chk(tid == 2'(i), "R6 wrap-cycle write deferred", tid, i);
            step();
        end
        chk(tid == 3, "R6 wrap-cycle write applied", tid, 3);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rotate();
        t_dead();
        t_table();
        t_len();
        t_wrap_write();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule